// File: doc/BRIEF.md
# Pipeline Hazard and Bypass Control

This block decides, every cycle, whether an in-order five-stage pipeline (fetch, decode, execute, memory, writeback) may advance. It also chooses where the execute stage takes its operands from. It reads the operation class and the register fields of the instructions currently sitting in decode, execute, memory and writeback. From these it drives four things: a hold for the fetch and decode registers (which also turns the execute slot into a bubble), a hold on fetch alone, a flush of the fetch/decode register, and operand bypass selects. The datapath, register file and memories are outside the block. It is purely combinational and sees only their control fields.

A two-bit mode input selects the bypass scheme. In mode 0 there is no bypass, and any read-after-write conflict with execute or memory waits in decode. In mode 1 the usual execute/memory and memory/writeback paths are used, so only a load feeding the next instruction stalls. Modes 2 and 3 keep mode 1 and add one more path: load data in the memory stage goes straight into the store-data operand in execute, so a store whose data comes from the load just ahead of it does not stall. Branches are resolved in execute. Fetch waits while a branch is in decode or execute, and a taken branch flushes the fetch/decode register. Fetch also yields the single memory port to any load or store in the memory stage.

Top module: `hazard_fwd_unit`

## Requirements
- R1: With every stage holding class 0 (no-op), all outputs are 0.
- R2: Class codes are 0 no-op, 1 ALU, 2 load, 3 store, 4 branch; 5 to 7 act as no-op. ALU, store and branch read both sources. Load reads only the first source. Only ALU and load write rd.
- R3: In mode 0, dec_hold is 1 when a source read by decode matches the rd of a writing instruction in execute or memory. All bypass selects are 0. A load followed by a dependent store therefore holds decode for 2 cycles.
- R4: In modes 1 to 3, dec_hold is 1 only when a source read by decode matches the rd of a load in execute. A dependent load-then-store pair thus holds for 1 cycle in mode 1.
- R5: In modes 2 and 3, a decode store's second (data) source matching a load in execute causes no hold. Its first (address) source still does, so the pair holds 0 cycles.
- R6: In modes 1 to 3, each execute source read gets a bypass select: 1 if the memory-stage instruction writes it and is an ALU op, and 0 if that writer is a load. Otherwise it is 2 if the writeback instruction writes it, else 0. The memory stage takes priority over writeback.
- R7: In modes 2 and 3, st_mem_bypass is 1 when execute holds a store whose data source matches the rd of a load in memory.
- R8: Register 0 as a source never creates a hold, a bypass or a store-data bypass.
- R9: fetch_hold is 1 while a branch is in decode or execute, giving 2 held cycles after each branch.
- R10: fetch_hold is 1 when memory holds a load or store, because the single memory port allows one access per cycle. It is also 1 whenever dec_hold is 1.
- R11: fd_flush is 1 exactly when execute holds a branch and ex_br_taken is 1.
- R12: rf_we is 1 only for an ALU or load in writeback with a nonzero rd, and rf_waddr equals wb_rd, so at most one write commits per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| byp_mode | input | 2 | Bypass scheme: 0 none, 1 normal, 2/3 normal plus memory-to-store path |
| dec_cls | input | 3 | Class of the decode instruction |
| dec_rs1 | input | REG_W | First source of the decode instruction |
| dec_rs2 | input | REG_W | Second source of the decode instruction |
| ex_cls | input | 3 | Class of the execute instruction |
| ex_rd | input | REG_W | Destination of the execute instruction |
| ex_rs1 | input | REG_W | First source of the execute instruction |
| ex_rs2 | input | REG_W | Second source of the execute instruction |
| ex_br_taken | input | 1 | Branch outcome computed in execute |
| mem_cls | input | 3 | Class of the memory-stage instruction |
| mem_rd | input | REG_W | Destination of the memory-stage instruction |
| wb_cls | input | 3 | Class of the writeback instruction |
| wb_rd | input | REG_W | Destination of the writeback instruction |
| fetch_hold | output | 1 | Fetch must not advance this cycle |
| dec_hold | output | 1 | Freeze fetch/decode registers, bubble into execute |
| fd_flush | output | 1 | Kill the fetch/decode register contents |
| fwd_a_sel | output | 2 | First-operand source: 0 register file, 1 execute/memory, 2 memory/writeback |
| fwd_b_sel | output | 2 | Second-operand source, same encoding |
| st_mem_bypass | output | 1 | Store data in execute taken from memory-stage load data |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | REG_W | Register file write address |

## Verification
The bench builds the block with REG_W = 2, so four registers, register 0 included, cover every match, mismatch and zero-register case. At that width two sweeps become exhaustive. The first crosses every mode with every decode class and source pair against every class and destination in execute and memory, which covers the 2, 1 and 0 hold counts of the load-then-store pair. The second crosses every execute class and source pair against every memory and writeback producer, which covers bypass priority, the load-in-memory case and the store-data path.

// File: rtl/hzu_pkg.sv
package hzu_pkg;

  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_ALU    = 3'd1,
    OP_LOAD   = 3'd2,
    OP_STORE  = 3'd3,
    OP_BRANCH = 3'd4
  } op_cls_e;

  localparam logic [1:0] SEL_RF    = 2'd0;
  localparam logic [1:0] SEL_EXMEM = 2'd1;
  localparam logic [1:0] SEL_MEMWB = 2'd2;

  localparam logic [1:0] MODE_NONE = 2'd0;

  localparam int NUM_SRC = 2;

  function automatic logic op_writes(input logic [2:0] c);
    return (c == OP_ALU) || (c == OP_LOAD);
  endfunction

  // idx 0: first source, idx 1: second source
  function automatic logic op_reads(input logic [2:0] c, input int idx);
    if (idx == 0)
      return (c == OP_ALU) || (c == OP_LOAD) || (c == OP_STORE) || (c == OP_BRANCH);
    return (c == OP_ALU) || (c == OP_STORE) || (c == OP_BRANCH);
  endfunction

  function automatic logic mode_ext(input logic [1:0] m);
    return m[1];
  endfunction

endpackage

// File: rtl/hzu_src_match.sv
module hzu_src_match #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic             src_used,
  input  logic [2:0]       prod_cls,
  input  logic [REG_W-1:0] prod_rd,
  output logic             hit
);
  import hzu_pkg::*;

  always_comb begin
    hit = src_used && (src != '0) && op_writes(prod_cls) && (prod_rd == src);
  end

endmodule

// File: rtl/hzu_stall_ctl.sv
module hzu_stall_ctl #(
  parameter int REG_W = 5
) (
  input  logic [1:0]       mode,
  input  logic [2:0]       d_cls,
  input  logic [REG_W-1:0] d_rs1,
  input  logic [REG_W-1:0] d_rs2,
  input  logic [2:0]       e_cls,
  input  logic [REG_W-1:0] e_rd,
  input  logic [2:0]       m_cls,
  input  logic [REG_W-1:0] m_rd,
  output logic             hold
);
  import hzu_pkg::*;

  logic [REG_W-1:0] srcs [NUM_SRC];
  logic [NUM_SRC-1:0] hit_e, hit_m, need;

  assign srcs[0] = d_rs1;
  assign srcs[1] = d_rs2;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    hzu_src_match #(.REG_W(REG_W)) i_me (
      .src(srcs[k]), .src_used(op_reads(d_cls, k)),
      .prod_cls(e_cls), .prod_rd(e_rd), .hit(hit_e[k]));
    hzu_src_match #(.REG_W(REG_W)) i_mm (
      .src(srcs[k]), .src_used(op_reads(d_cls, k)),
      .prod_cls(m_cls), .prod_rd(m_rd), .hit(hit_m[k]));

    always_comb begin
      if (mode == MODE_NONE)
        need[k] = hit_e[k] | hit_m[k];
      else if (mode_ext(mode) && (k == 1) && (d_cls == OP_STORE))
        need[k] = 1'b0;
      else
        need[k] = hit_e[k] && (e_cls == OP_LOAD);
    end
  end

  assign hold = |need;

  always_comb begin
    assert_only_load_stalls_R4: assert (!(mode != MODE_NONE && e_cls != OP_LOAD && hold))
      else $error("hold with bypass on and no load in execute");
    assert_r0_free_R8: assert (!(d_rs1 == '0 && d_rs2 == '0 && hold))
      else $error("hold caused by register 0");
  end

endmodule

// File: rtl/hzu_fwd_sel.sv
module hzu_fwd_sel #(
  parameter int REG_W = 5
) (
  input  logic [1:0]       mode,
  input  logic [REG_W-1:0] src,
  input  logic             src_used,
  input  logic [2:0]       m_cls,
  input  logic [REG_W-1:0] m_rd,
  input  logic [2:0]       w_cls,
  input  logic [REG_W-1:0] w_rd,
  output logic [1:0]       sel
);
  import hzu_pkg::*;

  logic hit_m, hit_w;

  hzu_src_match #(.REG_W(REG_W)) i_mm (
    .src(src), .src_used(src_used), .prod_cls(m_cls), .prod_rd(m_rd), .hit(hit_m));
  hzu_src_match #(.REG_W(REG_W)) i_mw (
    .src(src), .src_used(src_used), .prod_cls(w_cls), .prod_rd(w_rd), .hit(hit_w));

  always_comb begin
    if (mode == MODE_NONE)
      sel = SEL_RF;
    else if (hit_m)
      sel = (m_cls == OP_ALU) ? SEL_EXMEM : SEL_RF;
    else if (hit_w)
      sel = SEL_MEMWB;
    else
      sel = SEL_RF;
  end

  always_comb begin
    assert_exmem_alu_R6: assert (!(sel == SEL_EXMEM && m_cls != OP_ALU))
      else $error("execute/memory bypass without ALU producer");
    assert_memwb_match_R6: assert (!(sel == SEL_MEMWB && w_rd != src))
      else $error("memory/writeback bypass of wrong register");
  end

endmodule

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit #(
  parameter int REG_W = 5
) (
  input  logic [1:0]       byp_mode,
  input  logic [2:0]       dec_cls,
  input  logic [REG_W-1:0] dec_rs1,
  input  logic [REG_W-1:0] dec_rs2,
  input  logic [2:0]       ex_cls,
  input  logic [REG_W-1:0] ex_rd,
  input  logic [REG_W-1:0] ex_rs1,
  input  logic [REG_W-1:0] ex_rs2,
  input  logic             ex_br_taken,
  input  logic [2:0]       mem_cls,
  input  logic [REG_W-1:0] mem_rd,
  input  logic [2:0]       wb_cls,
  input  logic [REG_W-1:0] wb_rd,
  output logic             fetch_hold,
  output logic             dec_hold,
  output logic             fd_flush,
  output logic [1:0]       fwd_a_sel,
  output logic [1:0]       fwd_b_sel,
  output logic             st_mem_bypass,
  output logic             rf_we,
  output logic [REG_W-1:0] rf_waddr
);
  import hzu_pkg::*;

  logic [REG_W-1:0] ex_src [NUM_SRC];
  logic [1:0]       ex_sel [NUM_SRC];
  logic             st_hit;
  logic             br_pending, mem_busy;

  hzu_stall_ctl #(.REG_W(REG_W)) i_stall (
    .mode(byp_mode), .d_cls(dec_cls), .d_rs1(dec_rs1), .d_rs2(dec_rs2),
    .e_cls(ex_cls), .e_rd(ex_rd), .m_cls(mem_cls), .m_rd(mem_rd),
    .hold(dec_hold));

  assign ex_src[0] = ex_rs1;
  assign ex_src[1] = ex_rs2;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_fwd
    hzu_fwd_sel #(.REG_W(REG_W)) i_sel (
      .mode(byp_mode), .src(ex_src[k]), .src_used(op_reads(ex_cls, k)),
      .m_cls(mem_cls), .m_rd(mem_rd), .w_cls(wb_cls), .w_rd(wb_rd),
      .sel(ex_sel[k]));
  end

  assign fwd_a_sel = ex_sel[0];
  assign fwd_b_sel = ex_sel[1];

  hzu_src_match #(.REG_W(REG_W)) i_st (
    .src(ex_rs2), .src_used(ex_cls == OP_STORE),
    .prod_cls(mem_cls), .prod_rd(mem_rd), .hit(st_hit));

  always_comb begin
    st_mem_bypass = mode_ext(byp_mode) && st_hit && (mem_cls == OP_LOAD);
    br_pending    = (dec_cls == OP_BRANCH) || (ex_cls == OP_BRANCH);
    mem_busy      = (mem_cls == OP_LOAD) || (mem_cls == OP_STORE);
    fetch_hold    = br_pending || mem_busy || dec_hold;
    fd_flush      = (ex_cls == OP_BRANCH) && ex_br_taken;
    rf_we         = op_writes(wb_cls) && (wb_rd != '0);
    rf_waddr      = wb_rd;
  end

  always_comb begin
    assert_bypass_excl_R7: assert (!(st_mem_bypass && fwd_b_sel != SEL_RF))
      else $error("store-data bypass overlaps normal bypass");
    assert_flush_holds_R11: assert (!(fd_flush && !fetch_hold))
      else $error("flush while fetch runs");
    assert_one_write_R12: assert (!(rf_we && rf_waddr == '0))
      else $error("write to register 0");
    assert_dec_fetch_R10: assert (!(dec_hold && !fetch_hold))
      else $error("decode held while fetch runs");
  end

endmodule

// File: tb/test_hazard_fwd_unit.sv
`timescale 1ns/1ps
module test_hazard_fwd_unit;
  localparam int RW = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0] byp_mode;
  logic [2:0] dec_cls, ex_cls, mem_cls, wb_cls;
  logic [RW-1:0] dec_rs1, dec_rs2, ex_rd, ex_rs1, ex_rs2, mem_rd, wb_rd;
  logic ex_br_taken;
  logic fetch_hold, dec_hold, fd_flush, st_mem_bypass, rf_we;
  logic [1:0] fwd_a_sel, fwd_b_sel;
  logic [RW-1:0] rf_waddr;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  hazard_fwd_unit #(.REG_W(RW)) i_hazard_fwd_unit (.*);

  function automatic bit wr(input int c); return c == 1 || c == 2; endfunction
  function automatic bit rd_a(input int c); return c >= 1 && c <= 4; endfunction
  function automatic bit rd_b(input int c); return c == 1 || c == 3 || c == 4; endfunction
  function automatic bit dep(input int s, input bit used, input int pc, input int prd);
    return used && s != 0 && wr(pc) && prd == s;
  endfunction

  function automatic int fsel(input int md, input int s, input bit used,
                              input int mc, input int mr, input int wc, input int wrr);
    if (md == 0) return 0;
    if (dep(s, used, mc, mr)) return (mc == 1) ? 1 : 0;
    if (dep(s, used, wc, wrr)) return 2;
    return 0;
  endfunction

  task automatic cmp(input string req, input string nm, input int act, input int exp, inout bit bad);
    if (act != exp) begin
      $display("FAIL %s %s actual=%0d expected=%0d (mode=%0d d=%0d/%0d/%0d e=%0d rd%0d %0d/%0d m=%0d rd%0d w=%0d rd%0d)",
               req, nm, act, exp, byp_mode, dec_cls, dec_rs1, dec_rs2, ex_cls, ex_rd,
               ex_rs1, ex_rs2, mem_cls, mem_rd, wb_cls, wb_rd);
      bad = 1;
    end
  endtask

  task automatic check_vec();
    int md = byp_mode, dc = dec_cls, ec = ex_cls, mc = mem_cls, wc = wb_cls;
    bit ext = md >= 2;
    bit ea, eb, ma, mb, h_a, h_b, hold, fh, bad;
    int sa, sb;
    bit sbyp, flush, we;
    // R3/R4/R5/R8: decode hold
    ea = dep(dec_rs1, rd_a(dc), ec, ex_rd);
    eb = dep(dec_rs2, rd_b(dc), ec, ex_rd);
    ma = dep(dec_rs1, rd_a(dc), mc, mem_rd);
    mb = dep(dec_rs2, rd_b(dc), mc, mem_rd);
    if (md == 0) begin
      h_a = ea || ma; h_b = eb || mb;
    end else begin
      h_a = ea && ec == 2;
      h_b = eb && ec == 2 && !(ext && dc == 3);
    end
    hold = h_a || h_b;
    // R6: bypass selects
    sa = fsel(md, ex_rs1, rd_a(ec), mc, mem_rd, wc, wb_rd);
    sb = fsel(md, ex_rs2, rd_b(ec), mc, mem_rd, wc, wb_rd);
    // R7
    sbyp = ext && ec == 3 && mc == 2 && ex_rs2 != 0 && mem_rd == ex_rs2;
    // R9/R10
    fh = dc == 4 || ec == 4 || mc == 2 || mc == 3 || hold;
    // R11/R12
    flush = ec == 4 && ex_br_taken;
    we = wr(wc) && wb_rd != 0;
    #0.25;
    bad = 0;
    n_chk++;
    cmp("R3/R4/R5/R8", "dec_hold", dec_hold, hold, bad);
    cmp("R9/R10", "fetch_hold", fetch_hold, fh, bad);
    cmp("R11", "fd_flush", fd_flush, flush, bad);
    cmp("R6/R8", "fwd_a_sel", fwd_a_sel, sa, bad);
    cmp("R6/R8", "fwd_b_sel", fwd_b_sel, sb, bad);
    cmp("R7", "st_mem_bypass", st_mem_bypass, sbyp, bad);
    cmp("R12", "rf_we", rf_we, we, bad);
    if (we) cmp("R12", "rf_waddr", rf_waddr, wb_rd, bad);
    if (bad) n_bad++;
    #0.75;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 200000) begin
      $display("FAIL watchdog actual=%0d expected=<200000 cycles", cyc);
      n_bad++;
      finish_run();
    end
  end

  initial begin
    byp_mode = 0; dec_cls = 0; ex_cls = 0; mem_cls = 0; wb_cls = 0;
    dec_rs1 = 0; dec_rs2 = 0; ex_rd = 0; ex_rs1 = 0; ex_rs2 = 0;
    mem_rd = 0; wb_rd = 0; ex_br_taken = 0;
    #1;
    // R1: all no-op idle state, every output 0 (also checked against the model)
    #0.25;
    n_chk++;
    if ({fetch_hold, dec_hold, fd_flush, fwd_a_sel, fwd_b_sel, st_mem_bypass, rf_we} != '0) begin
      $display("FAIL R1 idle outputs actual=%0b expected=0",
               {fetch_hold, dec_hold, fd_flush, fwd_a_sel, fwd_b_sel, st_mem_bypass, rf_we});
      n_bad++;
    end
    #0.75;
    // Sweep 1 (R2 R3 R4 R5 R8 R9 R10): decode against execute and memory producers
    for (int md = 0; md < 4; md++)
      for (int dc = 0; dc < 6; dc++)
        for (int r1 = 0; r1 < 4; r1++)
          for (int r2 = 0; r2 < 4; r2++)
            for (int ec = 0; ec < 5; ec++)
              for (int er = 0; er < 4; er++)
                for (int mc = 0; mc < 5; mc++)
                  for (int mr = 0; mr < 4; mr++) begin
                    byp_mode = 2'(md); dec_cls = 3'(dc); dec_rs1 = RW'(r1); dec_rs2 = RW'(r2);
                    ex_cls = 3'(ec); ex_rd = RW'(er); ex_rs1 = RW'(r2); ex_rs2 = RW'(r1);
                    mem_cls = 3'(mc); mem_rd = RW'(mr);
                    wb_cls = 3'((r1 + mc) % 5); wb_rd = RW'(er); ex_br_taken = er[0];
                    check_vec();
                  end
    // Sweep 2 (R2 R6 R7 R8 R11 R12): execute sources against memory and writeback producers
    for (int md = 0; md < 4; md++)
      for (int ec = 0; ec < 6; ec++)
        for (int s1 = 0; s1 < 4; s1++)
          for (int s2 = 0; s2 < 4; s2++)
            for (int mc = 0; mc < 5; mc++)
              for (int mr = 0; mr < 4; mr++)
                for (int wc = 0; wc < 5; wc++)
                  for (int wr_i = 0; wr_i < 4; wr_i++) begin
                    byp_mode = 2'(md); ex_cls = 3'(ec); ex_rs1 = RW'(s1); ex_rs2 = RW'(s2);
                    ex_rd = RW'(s1 ^ s2); ex_br_taken = s1[0];
                    mem_cls = 3'(mc); mem_rd = RW'(mr); wb_cls = 3'(wc); wb_rd = RW'(wr_i);
                    dec_cls = 3'((mc + wc) % 6); dec_rs1 = RW'(wr_i); dec_rs2 = RW'(mr);
                    check_vec();
                  end
    finish_run();
  end

endmodule